// File: doc/BRIEF.md
# Per-Port Shared Debounce Filter

This block cleans up the eight input pins of one general-purpose I/O port before the values reach the input register and the interrupt detection logic. Each raw pin first crosses a two-flop synchronizer. A pin can then either pass straight to its output or go through a settle filter. A filtered pin changes its output only when its synchronized input has held a new level for a programmed number of millisecond ticks.

All eight pins share one 8-bit settle-time register, so they all use the same time. Each pin has its own enable bit and its own stability counter. The enable bits are written through a masked write. In that write, the upper byte selects which pins are touched and the lower byte carries the new enable values. The millisecond tick comes from outside the block.

Top module: `port_debounce`

## Requirements
- R1: After reset the enable register and the settle-time register read 0. Two clock edges after reset is released, every output equals its raw input.
- R2: A write to address 0xF0 loads bus_wdata[7:0] into the settle-time register and ignores the upper bits. A read at 0xF0 returns the value in bits [7:0] with zeros above.
- R3: A write to address 0x30 updates enable bit i to bus_wdata[i] only where bus_wdata[8+i] is 1. Every other enable bit keeps its value. A read at 0x30 returns the enable bits in [7:0].
- R4: A pin whose enable bit is 0 drives its output with its raw input, delayed by the two synchronizer edges and by no tick.
- R5: For an enabled pin with settle time N > 0, the output takes the new level on the clock edge that samples the N-th tick counted while the input differs. It does not change earlier and it does not change without a tick.
- R6: When the synchronized input of an enabled pin returns to the output level, that pin's counter restarts from zero. A later change then needs N fresh ticks.
- R7: A settle time of 0 makes every pin behave as unfiltered, with the same timing as R4, whatever its enable bit.
- R8: If the settle time is lowered to a value at or below a pin's tick count so far, that pin takes its new level on the next tick.
- R9: Each pin counts on its own. Pins that start differing at different times update at different ticks.
- R10: A write to any other address changes neither register, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_raw | input | 8 | Raw, asynchronous pin levels |
| pin_filt | output | 8 | Synchronized and optionally filtered pin levels |

## Verification
The assertions check four things on every cycle. An active filter never moves its output in a cycle without a tick. A pin's counter is zero once its input matches its output. A masked write leaves unselected enable bits alone. Idle cycles and writes to other addresses leave both registers unchanged. Other behaviours only the bench's scenarios can show: the exact tick on which a filtered pin flips, the restart after a glitch, pins counting independently, the early flip after the settle time is lowered, and the pass-through timing of disabled pins and of a zero settle time.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int TIME_W = 8;
  typedef logic [TIME_W-1:0] settle_t;

  // True when one more tick brings the run length to the limit.
  function automatic logic settle_done(settle_t run, settle_t lim);
    return ({1'b0, run} + 1'b1) >= {1'b0, lim};
  endfunction

  // Saturating increment of the run length.
  function automatic settle_t run_step(settle_t run);
    return (run == '1) ? run : run + 1'b1;
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dbnc_regs.sv
module dbnc_regs
  import dbnc_pkg::*;
#(
  parameter int          PINS        = 8,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  ADDR_LIMIT  = 8'hF0,
  parameter logic [7:0]  ADDR_ENABLE = 8'h30,
  localparam int         DW          = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [PINS-1:0]   en_q,
  output settle_t           limit_q
);
  logic            hit_limit, hit_enable;
  logic [PINS-1:0] en_nxt;

  assign hit_limit  = (bus_addr == ADDR_W'(ADDR_LIMIT));
  assign hit_enable = (bus_addr == ADDR_W'(ADDR_ENABLE));

  // Masked merge: the upper half of the write selects, the lower half supplies.
  for (genvar b = 0; b < PINS; b++) begin : g_mask
    assign en_nxt[b] = (bus_wr && hit_enable && bus_wdata[PINS+b]) ? bus_wdata[b] : en_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      limit_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (bus_wr && hit_limit) limit_q <= bus_wdata[TIME_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_limit)       bus_rdata[TIME_W-1:0] = limit_q;
    else if (hit_enable) bus_rdata[PINS-1:0]   = en_q;
  end
endmodule

// File: rtl/dbnc_lane.sv
module dbnc_lane
  import dbnc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ms_tick,
  input  logic    en,
  input  settle_t limit,
  input  logic    pin_sync,
  output logic    pin_out,
  output logic    filt_q,
  output settle_t run_q
);
  logic active, differ;

  assign active = en && (limit != '0);
  assign differ = (pin_sync != filt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (!active || !differ) begin
      filt_q <= pin_sync;
      run_q  <= '0;
    end else if (ms_tick) begin
      if (settle_done(run_q, limit)) begin
        filt_q <= pin_sync;
        run_q  <= '0;
      end else begin
        run_q <= run_step(run_q);
      end
    end
  end

  assign pin_out = active ? filt_q : pin_sync;
endmodule

// File: rtl/port_debounce.sv
module port_debounce
  import dbnc_pkg::*;
#(
  parameter int         PINS        = 8,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ADDR_LIMIT  = 8'hF0,
  parameter logic [7:0] ADDR_ENABLE = 8'h30,
  localparam int        DW          = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [PINS-1:0]   pin_raw,
  output logic [PINS-1:0]   pin_filt
);
  logic [PINS-1:0]        en_q;
  settle_t                limit_q;
  logic [PINS-1:0]        sync_vec;
  logic [PINS-1:0]        filt_vec;
  logic [PINS*TIME_W-1:0] run_flat;

  dbnc_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_vec)
  );

  dbnc_regs #(
    .PINS(PINS), .ADDR_W(ADDR_W), .ADDR_LIMIT(ADDR_LIMIT), .ADDR_ENABLE(ADDR_ENABLE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q), .limit_q(limit_q)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_lane
    dbnc_lane u_lane (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .en(en_q[i]), .limit(limit_q),
      .pin_sync(sync_vec[i]), .pin_out(pin_filt[i]), .filt_q(filt_vec[i]),
      .run_q(run_flat[i*TIME_W +: TIME_W])
    );
  end
endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker
  import dbnc_pkg::*;
#(
  parameter int         PINS        = 8,
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] ADDR_LIMIT  = 8'hF0,
  parameter logic [7:0] ADDR_ENABLE = 8'h30
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ms_tick,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [2*PINS-1:0]      bus_wdata,
  input logic [PINS-1:0]        en_q,
  input settle_t                limit_q,
  input logic [PINS-1:0]        sync_vec,
  input logic [PINS-1:0]        filt_vec,
  input logic [PINS*TIME_W-1:0] run_flat
);
  logic wr_limit, wr_enable, wr_other;
  assign wr_limit  = bus_wr && (bus_addr == ADDR_W'(ADDR_LIMIT));
  assign wr_enable = bus_wr && (bus_addr == ADDR_W'(ADDR_ENABLE));
  assign wr_other  = bus_wr && !wr_limit && !wr_enable;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && limit_q == '0));

  p_limit_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_limit) |-> limit_q == $past(bus_wdata[TIME_W-1:0]));

  p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_enable) |->
      ((((en_q ^ $past(en_q)) & ~$past(bus_wdata[2*PINS-1:PINS])) == '0) &&
       (((en_q ^ $past(bus_wdata[PINS-1:0])) & $past(bus_wdata[2*PINS-1:PINS])) == '0)));

  p_regs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bus_wr) || $past(wr_other)) |-> ($stable(en_q) && $stable(limit_q)));

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_q[i]) && ($past(limit_q) != '0) && !$past(ms_tick)) |-> $stable(filt_vec[i]));

    p_run_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sync_vec[i]) == $past(filt_vec[i])) |-> (run_flat[i*TIME_W +: TIME_W] == '0));
  end
endmodule

bind port_debounce dbnc_checker #(
  .PINS(PINS), .ADDR_W(ADDR_W), .ADDR_LIMIT(ADDR_LIMIT), .ADDR_ENABLE(ADDR_ENABLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en_q(en_q), .limit_q(limit_q), .sync_vec(sync_vec),
  .filt_vec(filt_vec), .run_flat(run_flat)
);

// File: tb/tb_port_debounce.sv
module tb_port_debounce;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_raw = '0;
  logic [7:0]  pin_filt;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_rd;
    logic [15:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  port_debounce dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  always #(CLK_P/2) clk = ~clk;

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      logic [15:0] act;
      it  = sb.pop_front();
      act = it.is_rd ? bus_rdata : {8'h00, pin_filt};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic tick();
    ms_tick = 1'b1; @(posedge clk); #1; ms_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) tick();
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic expect_pins(logic [7:0] e, string tag);
    sb_item_t it;
    it.is_rd = 1'b0; it.exp = {8'h00, e}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expect_rd(logic [7:0] a, logic [15:0] e, string tag);
    sb_item_t it;
    bus_addr = a;
    it.is_rd = 1'b1; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    pin_raw = 8'hA5;
    idle(3);
    // R1: register state during reset
    expect_rd(8'hF0, 16'h0000, "R1 limit at reset");
    expect_rd(8'h30, 16'h0000, "R1 enable at reset");
    @(posedge clk); #1; rst_n = 1'b1;
    idle(2);
    expect_pins(8'hA5, "R1 outputs follow raw after reset");

    // R2: limit write, upper bits ignored
    wr(8'hF0, 16'hAB03);
    expect_rd(8'hF0, 16'h0003, "R2 limit readback");

    // R3: masked enable writes
    wr(8'h30, 16'h0F0F);
    expect_rd(8'h30, 16'h000F, "R3 enable all-mask write");
    wr(8'h30, 16'h3020);
    expect_rd(8'h30, 16'h002F, "R3 partial mask");
    wr(8'h30, 16'h00FF);
    expect_rd(8'h30, 16'h002F, "R3 empty mask ignored");
    wr(8'h30, 16'hF000);
    expect_rd(8'h30, 16'h000F, "R3 clear upper enables");

    // R10: other address
    wr(8'h44, 16'hFFFF);
    expect_rd(8'h44, 16'h0000, "R10 other address reads 0");
    expect_rd(8'hF0, 16'h0003, "R10 limit untouched");
    expect_rd(8'h30, 16'h000F, "R10 enable untouched");

    // R4: disabled upper nibble passes through after two edges
    pin_raw = 8'h55;
    idle(1);
    expect_pins(8'hA5, "R4 one edge after change");
    idle(1);
    expect_pins(8'h55, "R4 two edges after change");

    // R5: pin0 filtered, limit 3
    pin_raw = 8'h54;
    idle(3);
    expect_pins(8'h55, "R5 no tick yet");
    ticks(2);
    expect_pins(8'h55, "R5 after two ticks");
    tick();
    expect_pins(8'h54, "R5 after third tick");

    // R6: glitch restarts the count
    pin_raw = 8'h56;
    idle(3);
    ticks(2);
    pin_raw = 8'h54;
    idle(3);
    expect_pins(8'h54, "R6 glitch not passed");
    pin_raw = 8'h56;
    idle(3);
    ticks(2);
    expect_pins(8'h54, "R6 count restarted");
    tick();
    expect_pins(8'h56, "R6 settles after fresh ticks");

    // R9: pins 2 and 3 start at different times
    pin_raw = 8'h52;
    idle(3);
    tick();
    pin_raw = 8'h5A;
    idle(3);
    ticks(2);
    expect_pins(8'h52, "R9 pin2 done, pin3 pending");
    tick();
    expect_pins(8'h5A, "R9 pin3 done");

    // R8: lower the limit below progress
    wr(8'hF0, 16'h000A);
    pin_raw = 8'h5B;
    idle(3);
    ticks(4);
    expect_pins(8'h5A, "R8 still counting at limit 10");
    wr(8'hF0, 16'h0002);
    idle(1);
    expect_pins(8'h5A, "R8 no change without tick");
    tick();
    expect_pins(8'h5B, "R8 update on next tick");

    // R7: limit 0 makes enabled pins pass through
    wr(8'hF0, 16'h0000);
    pin_raw = 8'h53;
    idle(1);
    expect_pins(8'h5B, "R7 one edge after change");
    idle(1);
    expect_pins(8'h53, "R7 pass-through with zero limit");

    idle(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule